// File: doc/BRIEF.md
# Autonomous Channel Scan Sequencer

This block is the control engine of a satellite receiver front end. The host does not program the tuner and demodulator step by step. It loads a frequency window, a step size, a per-attempt timeout, a lock-confirmation length and two enable masks. One mask selects symbol-rate ranges and the other selects code (puncture) rates. A one-byte start command then begins a sweep. For each frequency, the sequencer tunes through a request/acknowledge handshake. It then runs one acquisition attempt for every enabled pair of symbol-rate range and code rate.

An attempt is reported only when the demodulator lock stays high for the programmed number of consecutive cycles, which filters out false locks. On a confirmed lock, the sequencer latches the frequency, range and rate into read-only registers. It raises an interrupt and parks until the host sends a resume command. Each attempt also tells the demodulator which acquisition procedure to use: a separate procedure for the lowest symbol-rate ranges and the normal one for the rest. A sweep that runs past the stop frequency ends with a done flag and an interrupt. An abort command returns the sequencer to idle from any state. A small register port gives direct read and write access to all settings and results.

Top module: `scan_sequencer`

## Requirements
- R1: After reset, the status register reads 0. The settings read back as start 950, stop 2150, step 10, timeout 64, confirm 4, and both masks all ones.
- R2: Command bytes are 0x01 start, 0x02 resume, 0x03 abort and 0x04 interrupt acknowledge. Any other byte, and resume outside the held state, has no effect on the status.
- R3: A sweep tunes start, start+step, and so on, while the frequency is not above stop. At each frequency it completes one tune request/acknowledge before any attempt. It then tries only the pairs whose range bit and rate bit are both set, with range index in the outer ascending loop and rate index in the inner ascending loop.
- R4: An unconfirmed attempt gives up after its timeout. At one frequency, each acq_start pulse follows the previous one by exactly timeout+3 cycles.
- R5: A lock is confirmed only after demod_lock stays high for the confirm count of consecutive cycles. Shorter runs are ignored and the sweep goes on.
- R6: A confirmed lock raises irq and sets status bit 1. It latches the frequency at address 9 and the code at address 10, with the range index in bits 8 and up and the rate index in bits 0 and up. No further attempt starts until resume. Resume clears irq and continues with the next pair.
- R7: A completed sweep clears busy (status bit 0) and sets done (bit 2) and irq (bit 3).
- R8: Abort returns the block to idle and clears irq in the next cycle, from any state.
- R9: Start is rejected when start < 950, stop > 2150, start > stop or step = 0. A rejected start sets status bit 4 and the block stays idle. An accepted start clears bit 4.
- R10: Writes to the settings are ignored while busy.
- R11: acq_low_rate is high during an attempt exactly when the range index is below LOW_SR_CNT (default 1).
- R12: Read data for reg_rd is presented on reg_rdata in the next cycle. The addresses are 0 start, 1 stop, 2 step, 3 timeout, 4 confirm, 5 range mask, 6 rate mask, 8 status, 9 locked frequency, 10 locked code and 11 current frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | One-byte command |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after reg_rd |
| tune_req | output | 1 | Tuner request, held until acknowledged |
| tune_freq | output | 12 | Tuning frequency in MHz |
| tune_ack | input | 1 | Tuner acknowledge |
| acq_start | output | 1 | One-cycle pulse starting an attempt |
| acq_sr | output | 2 | Symbol-rate range index of the attempt |
| acq_pr | output | 3 | Code-rate index of the attempt |
| acq_low_rate | output | 1 | Selects the low-symbol-rate acquisition procedure |
| demod_lock | input | 1 | Demodulator lock indication |
| irq | output | 1 | Interrupt: lock confirmed or sweep done |

## Verification
Register reads land on reg_rdata one cycle after the strobe, so every read task samples at the falling edge that follows the strobe's clock edge. Attempts are compared in a scoreboard at the falling edge of each acq_start pulse. The attempt spacing at one frequency is checked against timeout+3 cycles, which counts the restart cycle, the timeout window and the one selection cycle. The lock comes from a bench model that holds demod_lock high, or toggles it, only for one target frequency and pair. A steady lock must therefore end in a hold with the scoreboard stopped exactly after the target. A toggling lock must let the sweep run to done. Hold and idle checks watch for attempts over a fixed window of cycles before any next command is sent.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TUNE,
        S_SEL,
        S_ACQ,
        S_HOLD
    } scan_state_e;

    localparam logic [7:0] CMD_START   = 8'h01;
    localparam logic [7:0] CMD_RESUME  = 8'h02;
    localparam logic [7:0] CMD_ABORT   = 8'h03;
    localparam logic [7:0] CMD_IRQ_ACK = 8'h04;

    localparam logic [3:0] A_START   = 4'd0;
    localparam logic [3:0] A_STOP    = 4'd1;
    localparam logic [3:0] A_STEP    = 4'd2;
    localparam logic [3:0] A_TMO     = 4'd3;
    localparam logic [3:0] A_CNF     = 4'd4;
    localparam logic [3:0] A_SRMASK  = 4'd5;
    localparam logic [3:0] A_PRMASK  = 4'd6;
    localparam logic [3:0] A_STATUS  = 4'd8;
    localparam logic [3:0] A_HITF    = 4'd9;
    localparam logic [3:0] A_HITCODE = 4'd10;
    localparam logic [3:0] A_CURF    = 4'd11;

    localparam int unsigned BAND_LO = 950;
    localparam int unsigned BAND_HI = 2150;

    // packed lsb first from the bottom: busy is bit 0
    typedef struct packed {
        logic cfg_err;
        logic irq;
        logic done;
        logic hold;
        logic busy;
    } scan_status_t;

    function automatic logic band_ok(input int unsigned f_lo,
                                     input int unsigned f_hi,
                                     input int unsigned f_step);
        return (f_lo >= BAND_LO) && (f_hi <= BAND_HI) &&
               (f_lo <= f_hi) && (f_step != 0);
    endfunction

endpackage

// File: rtl/scan_regs.sv
module scan_regs
    import scan_pkg::*;
#(
    parameter int FREQ_W = 12,
    parameter int NSR    = 4,
    parameter int NPR    = 5,
    parameter int TMO_W  = 16,
    parameter int CNF_W  = 8,
    parameter int DW     = 16,
    localparam int SR_W  = (NSR > 1) ? $clog2(NSR) : 1,
    localparam int PR_W  = (NPR > 1) ? $clog2(NPR) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [3:0]         reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_byte,
    input  scan_status_t       status,
    input  logic [FREQ_W-1:0]  hit_f,
    input  logic [SR_W-1:0]    hit_sr,
    input  logic [PR_W-1:0]    hit_pr,
    input  logic [FREQ_W-1:0]  cur_f,
    output logic [FREQ_W-1:0]  cfg_start,
    output logic [FREQ_W-1:0]  cfg_stop,
    output logic [FREQ_W-1:0]  cfg_step,
    output logic [TMO_W-1:0]   cfg_tmo,
    output logic [CNF_W-1:0]   cfg_cnf,
    output logic [NSR-1:0]     cfg_srmask,
    output logic [NPR-1:0]     cfg_prmask,
    output logic               go_start,
    output logic               go_resume,
    output logic               go_abort,
    output logic               go_ack
);

    assign go_start  = cmd_valid && (cmd_byte == CMD_START);
    assign go_resume = cmd_valid && (cmd_byte == CMD_RESUME);
    assign go_abort  = cmd_valid && (cmd_byte == CMD_ABORT);
    assign go_ack    = cmd_valid && (cmd_byte == CMD_IRQ_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_start  <= FREQ_W'(BAND_LO);
            cfg_stop   <= FREQ_W'(BAND_HI);
            cfg_step   <= FREQ_W'(10);
            cfg_tmo    <= TMO_W'(64);
            cfg_cnf    <= CNF_W'(4);
            cfg_srmask <= '1;
            cfg_prmask <= '1;
        end else if (reg_wr && !status.busy) begin
            case (reg_addr)
                A_START:  cfg_start  <= reg_wdata[FREQ_W-1:0];
                A_STOP:   cfg_stop   <= reg_wdata[FREQ_W-1:0];
                A_STEP:   cfg_step   <= reg_wdata[FREQ_W-1:0];
                A_TMO:    cfg_tmo    <= reg_wdata[TMO_W-1:0];
                A_CNF:    cfg_cnf    <= reg_wdata[CNF_W-1:0];
                A_SRMASK: cfg_srmask <= reg_wdata[NSR-1:0];
                A_PRMASK: cfg_prmask <= reg_wdata[NPR-1:0];
                default:  ;
            endcase
        end
    end

    logic [DW-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            A_START:   rd_mux = DW'(cfg_start);
            A_STOP:    rd_mux = DW'(cfg_stop);
            A_STEP:    rd_mux = DW'(cfg_step);
            A_TMO:     rd_mux = DW'(cfg_tmo);
            A_CNF:     rd_mux = DW'(cfg_cnf);
            A_SRMASK:  rd_mux = DW'(cfg_srmask);
            A_PRMASK:  rd_mux = DW'(cfg_prmask);
            A_STATUS:  rd_mux = DW'(status);
            A_HITF:    rd_mux = DW'(hit_f);
            A_HITCODE: begin
                rd_mux[8 +: SR_W] = hit_sr;
                rd_mux[0 +: PR_W] = hit_pr;
            end
            A_CURF:    rd_mux = DW'(cur_f);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/scan_combo_sel.sv
module scan_combo_sel #(
    parameter int NSR   = 4,
    parameter int NPR   = 5,
    localparam int SR_W = (NSR > 1) ? $clog2(NSR) : 1,
    localparam int PR_W = (NPR > 1) ? $clog2(NPR) : 1
) (
    input  logic [NSR-1:0]  srmask,
    input  logic [NPR-1:0]  prmask,
    input  logic            first,
    input  logic [SR_W-1:0] cur_sr,
    input  logic [PR_W-1:0] cur_pr,
    output logic            found,
    output logic [SR_W-1:0] nxt_sr,
    output logic [PR_W-1:0] nxt_pr
);

    int cur_k;

    // descending scan: the last hit written is the lowest eligible pair
    always_comb begin
        cur_k  = int'(cur_sr) * NPR + int'(cur_pr);
        found  = 1'b0;
        nxt_sr = '0;
        nxt_pr = '0;
        for (int s = NSR - 1; s >= 0; s--) begin
            for (int p = NPR - 1; p >= 0; p--) begin
                if (srmask[s] && prmask[p] && (first || (s * NPR + p > cur_k))) begin
                    found  = 1'b1;
                    nxt_sr = SR_W'(s);
                    nxt_pr = PR_W'(p);
                end
            end
        end
    end

endmodule

// File: rtl/scan_lock_qual.sv
module scan_lock_qual #(
    parameter int TMO_W = 16,
    parameter int CNF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             restart,
    input  logic             lock,
    input  logic [TMO_W-1:0] tmo_lim,
    input  logic [CNF_W-1:0] cnf_lim,
    output logic             confirmed,
    output logic             expired
);

    logic [TMO_W-1:0] tmo_cnt;
    logic [CNF_W-1:0] run_cnt;
    logic [CNF_W-1:0] cnf_eff;

    assign cnf_eff = (cnf_lim == '0) ? CNF_W'(1) : cnf_lim;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tmo_cnt <= '0;
            run_cnt <= '0;
        end else if (active) begin
            if (tmo_cnt != '1) begin
                tmo_cnt <= tmo_cnt + 1'b1;
            end
            if (!lock) begin
                run_cnt <= '0;
            end else if (run_cnt != '1) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign confirmed = active && !restart && (run_cnt >= cnf_eff);
    assign expired   = active && !restart && (tmo_cnt >= tmo_lim);

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_pkg::*;
#(
    parameter int FREQ_W     = 12,
    parameter int NSR        = 4,
    parameter int NPR        = 5,
    parameter int TMO_W      = 16,
    parameter int CNF_W      = 8,
    parameter int DW         = 16,
    parameter int LOW_SR_CNT = 1,
    localparam int SR_W      = (NSR > 1) ? $clog2(NSR) : 1,
    localparam int PR_W      = (NPR > 1) ? $clog2(NPR) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              tune_req,
    output logic [FREQ_W-1:0] tune_freq,
    input  logic              tune_ack,
    output logic              acq_start,
    output logic [SR_W-1:0]   acq_sr,
    output logic [PR_W-1:0]   acq_pr,
    output logic              acq_low_rate,
    input  logic              demod_lock,
    output logic              irq
);

    scan_state_e       state;
    logic [FREQ_W-1:0] cur_f;
    logic [SR_W-1:0]   cur_sr;
    logic [PR_W-1:0]   cur_pr;
    logic              sel_first;
    logic              irq_q;
    logic              done_q;
    logic              err_q;
    logic [FREQ_W-1:0] hit_f;
    logic [SR_W-1:0]   hit_sr;
    logic [PR_W-1:0]   hit_pr;
    logic              st_busy;
    logic              st_hold;
    scan_status_t      status;

    logic [FREQ_W-1:0] cfg_start;
    logic [FREQ_W-1:0] cfg_stop;
    logic [FREQ_W-1:0] cfg_step;
    logic [TMO_W-1:0]  cfg_tmo;
    logic [CNF_W-1:0]  cfg_cnf;
    logic [NSR-1:0]    cfg_srmask;
    logic [NPR-1:0]    cfg_prmask;
    logic              go_start;
    logic              go_resume;
    logic              go_abort;
    logic              go_ack;

    logic              sel_found;
    logic [SR_W-1:0]   sel_sr;
    logic [PR_W-1:0]   sel_pr;
    logic              confirmed;
    logic              expired;
    logic [FREQ_W:0]   next_f;
    logic              cfg_ok;

    assign st_busy = (state != S_IDLE);
    assign st_hold = (state == S_HOLD);
    assign status  = '{cfg_err: err_q, irq: irq_q, done: done_q,
                       hold: st_hold, busy: st_busy};

    scan_regs #(
        .FREQ_W(FREQ_W), .NSR(NSR), .NPR(NPR),
        .TMO_W(TMO_W), .CNF_W(CNF_W), .DW(DW)
    ) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .status(status), .hit_f(hit_f), .hit_sr(hit_sr), .hit_pr(hit_pr),
        .cur_f(cur_f),
        .cfg_start(cfg_start), .cfg_stop(cfg_stop), .cfg_step(cfg_step),
        .cfg_tmo(cfg_tmo), .cfg_cnf(cfg_cnf),
        .cfg_srmask(cfg_srmask), .cfg_prmask(cfg_prmask),
        .go_start(go_start), .go_resume(go_resume),
        .go_abort(go_abort), .go_ack(go_ack)
    );

    scan_combo_sel #(.NSR(NSR), .NPR(NPR)) u_sel (
        .srmask(cfg_srmask), .prmask(cfg_prmask),
        .first(sel_first), .cur_sr(cur_sr), .cur_pr(cur_pr),
        .found(sel_found), .nxt_sr(sel_sr), .nxt_pr(sel_pr)
    );

    scan_lock_qual #(.TMO_W(TMO_W), .CNF_W(CNF_W)) u_qual (
        .clk(clk), .rst(rst),
        .active(state == S_ACQ), .restart(acq_start), .lock(demod_lock),
        .tmo_lim(cfg_tmo), .cnf_lim(cfg_cnf),
        .confirmed(confirmed), .expired(expired)
    );

    assign next_f = {1'b0, cur_f} + {1'b0, cfg_step};
    assign cfg_ok = band_ok(32'(cfg_start), 32'(cfg_stop), 32'(cfg_step));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cur_f     <= '0;
            cur_sr    <= '0;
            cur_pr    <= '0;
            sel_first <= 1'b1;
            acq_start <= 1'b0;
            irq_q     <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            hit_f     <= '0;
            hit_sr    <= '0;
            hit_pr    <= '0;
        end else begin
            acq_start <= 1'b0;
            if (go_ack) begin
                irq_q <= 1'b0;
            end
            if (go_abort) begin
                state <= S_IDLE;
                irq_q <= 1'b0;
            end else begin
                case (state)
                    S_IDLE: begin
                        if (go_start) begin
                            if (cfg_ok) begin
                                state  <= S_TUNE;
                                cur_f  <= cfg_start;
                                err_q  <= 1'b0;
                                done_q <= 1'b0;
                                irq_q  <= 1'b0;
                            end else begin
                                err_q <= 1'b1;
                            end
                        end
                    end
                    S_TUNE: begin
                        if (tune_ack) begin
                            state     <= S_SEL;
                            sel_first <= 1'b1;
                        end
                    end
                    S_SEL: begin
                        if (sel_found) begin
                            cur_sr    <= sel_sr;
                            cur_pr    <= sel_pr;
                            acq_start <= 1'b1;
                            state     <= S_ACQ;
                        end else if (next_f > {1'b0, cfg_stop}) begin
                            state  <= S_IDLE;
                            done_q <= 1'b1;
                            irq_q  <= 1'b1;
                        end else begin
                            cur_f <= next_f[FREQ_W-1:0];
                            state <= S_TUNE;
                        end
                    end
                    S_ACQ: begin
                        if (confirmed) begin
                            state  <= S_HOLD;
                            hit_f  <= cur_f;
                            hit_sr <= cur_sr;
                            hit_pr <= cur_pr;
                            irq_q  <= 1'b1;
                        end else if (expired) begin
                            state     <= S_SEL;
                            sel_first <= 1'b0;
                        end
                    end
                    S_HOLD: begin
                        if (go_resume) begin
                            state     <= S_SEL;
                            sel_first <= 1'b0;
                            irq_q     <= 1'b0;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    assign tune_req     = (state == S_TUNE);
    assign tune_freq    = cur_f;
    assign acq_sr       = cur_sr;
    assign acq_pr       = cur_pr;
    assign acq_low_rate = (int'(cur_sr) < LOW_SR_CNT);
    assign irq          = irq_q;

endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk
    import scan_pkg::*;
#(
    parameter int FREQ_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [7:0]        cmd_byte,
    input logic              reg_wr,
    input logic              tune_req,
    input logic              tune_ack,
    input logic [FREQ_W-1:0] tune_freq,
    input logic              acq_start,
    input logic              demod_lock,
    input logic              irq,
    input logic              st_busy,
    input logic              st_hold,
    input logic              done_q,
    input logic [FREQ_W-1:0] cfg_start
);

    assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
        (tune_req && !tune_ack) |=> tune_req);

    assert_in_band_R9: assert property (@(posedge clk) disable iff (rst)
        tune_req |-> (32'(tune_freq) >= BAND_LO && 32'(tune_freq) <= BAND_HI));

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_byte == CMD_ABORT) |=> (!irq && !st_busy));

    assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        st_hold |-> !acq_start);

    assert_lock_before_hold_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(st_hold) |-> $past(demod_lock));

    assert_done_irq_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> (irq && !st_busy));

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (st_busy && reg_wr) |=> $stable(cfg_start));

endmodule

bind scan_sequencer scan_sequencer_chk #(.FREQ_W(FREQ_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .reg_wr(reg_wr), .tune_req(tune_req), .tune_ack(tune_ack),
    .tune_freq(tune_freq), .acq_start(acq_start), .demod_lock(demod_lock),
    .irq(irq), .st_busy(st_busy), .st_hold(st_hold), .done_q(done_q),
    .cfg_start(cfg_start)
);

// File: tb/scan_sequencer_bench.sv
module scan_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        tune_req;
    logic [11:0] tune_freq;
    logic        tune_ack = 1'b0;
    logic        acq_start;
    logic [1:0]  acq_sr;
    logic [2:0]  acq_pr;
    logic        acq_low_rate;
    logic        demod_lock;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    int exp_q[$];
    int attempts = 0;
    int cyc = 0;
    int last_cyc = 0;
    int last_f = -1;
    bit gap_chk = 0;
    int tmo_val = 12;
    int lock_mode = 0;
    int tgt_f = 0;
    int tgt_sr = 0;
    int tgt_pr = 0;
    bit flick = 0;
    int tdly = 0;

    scan_sequencer u_scan_sequencer (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tune_req(tune_req), .tune_freq(tune_freq), .tune_ack(tune_ack),
        .acq_start(acq_start), .acq_sr(acq_sr), .acq_pr(acq_pr),
        .acq_low_rate(acq_low_rate), .demod_lock(demod_lock), .irq(irq)
    );

    always #2ns clk = ~clk;

    assign demod_lock = (lock_mode != 0) && (int'(tune_freq) == tgt_f) &&
                        (int'(acq_sr) == tgt_sr) && (int'(acq_pr) == tgt_pr) &&
                        (lock_mode == 1 || flick);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // tuner and lock-flicker model, plus the attempt monitor
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            flick = ~flick;
            if (tune_req && !tune_ack) begin
                tdly++;
                if (tdly >= 2) begin
                    tune_ack = 1'b1;
                    tdly = 0;
                end
            end else begin
                tune_ack = 1'b0;
            end
            if (acq_start) begin
                int got;
                got = int'(tune_freq) * 256 + int'(acq_sr) * 16 + int'(acq_pr);
                attempts++;
                if (exp_q.size() == 0) begin
                    check(0, "R3 unexpected attempt", got, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(got == e, "R3 attempt order", got, e);
                end
                check(acq_low_rate == (acq_sr < 2'd1), "R11 procedure select",
                      int'(acq_low_rate), int'(acq_sr < 2'd1));
                if (gap_chk && int'(tune_freq) == last_f)
                    check(cyc - last_cyc == tmo_val + 3, "R4 attempt spacing",
                          cyc - last_cyc, tmo_val + 3);
                last_cyc = cyc;
                last_f = int'(tune_freq);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = 16'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = int'(reg_rdata);
    endtask

    task automatic cmd(input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic push_plan(input int f0, input int f1, input int st,
                             input int srm, input int prm);
        for (int f = f0; f <= f1; f += st)
            for (int s = 0; s < 4; s++)
                for (int p = 0; p < 5; p++)
                    if (srm[s] && prm[p]) exp_q.push_back(f * 256 + s * 16 + p);
    endtask

    task automatic wait_irq(input string tag);
        int n;
        n = 0;
        while (!irq && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(irq == 1'b1, tag, int'(irq), 1);
    endtask

    initial begin
        #(4ns * 150000);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int v;
        int a0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R12 reset state through the register port
        rd(4'd8, v);  check(v == 0, "R1 status after reset", v, 0);
        rd(4'd0, v);  check(v == 950, "R1 start default", v, 950);
        rd(4'd1, v);  check(v == 2150, "R12 stop default", v, 2150);
        rd(4'd2, v);  check(v == 10, "R1 step default", v, 10);
        rd(4'd3, v);  check(v == 64, "R1 timeout default", v, 64);
        rd(4'd4, v);  check(v == 4, "R1 confirm default", v, 4);
        rd(4'd6, v);  check(v == 31, "R1 rate mask default", v, 31);

        wr(4'd1, 985);
        wr(4'd3, tmo_val);
        wr(4'd5, 5);      // ranges 0 and 2
        wr(4'd6, 18);     // rates 1 and 4

        // R3 R4 R7: full sweep with no signal
        gap_chk = 1;
        push_plan(950, 985, 10, 5, 18);
        cmd(8'h01);
        wait_irq("R7 irq at sweep end");
        gap_chk = 0;
        check(exp_q.size() == 0, "R3 all pairs tried", exp_q.size(), 0);
        check(attempts == 16, "R4 attempts advance on timeout", attempts, 16);
        rd(4'd8, v);  check(v == 12, "R7 status done", v, 12);
        cmd(8'h04);
        rd(4'd8, v);  check(v == 4, "R2 irq ack", v, 4);

        // R2: resume while idle and unknown byte have no effect
        a0 = attempts;
        cmd(8'h02);
        cmd(8'h7F);
        repeat (20) @(negedge clk);
        rd(4'd8, v);  check(v == 4, "R2 ignored commands", v, 4);
        check(attempts == a0, "R2 no attempt when idle", attempts, a0);

        // R6: steady lock at 970 MHz, range 2, rate 1
        lock_mode = 1; tgt_f = 970; tgt_sr = 2; tgt_pr = 1;
        push_plan(950, 985, 10, 5, 18);
        cmd(8'h01);
        wait_irq("R6 irq on lock");
        check(exp_q.size() == 5, "R6 stop at target", exp_q.size(), 5);
        rd(4'd8, v);  check(v == 11, "R6 status held", v, 11);
        rd(4'd9, v);  check(v == 970, "R6 locked frequency", v, 970);
        rd(4'd10, v); check(v == 513, "R6 locked code", v, 513);
        a0 = attempts;
        cmd(8'h7F);
        repeat (40) @(negedge clk);
        check(attempts == a0, "R6 held without attempts", attempts, a0);
        rd(4'd8, v);  check(v == 11, "R2 unknown byte in hold", v, 11);
        lock_mode = 0;
        cmd(8'h02);
        check(irq == 1'b0, "R6 resume clears irq", int'(irq), 0);
        wait_irq("R7 irq after resumed sweep");
        check(exp_q.size() == 0, "R6 resume continues", exp_q.size(), 0);
        rd(4'd8, v);  check(v == 12, "R7 done after resume", v, 12);

        // R5: toggling lock never confirms
        lock_mode = 2;
        push_plan(950, 985, 10, 5, 18);
        cmd(8'h01);
        wait_irq("R5 irq at end");
        rd(4'd8, v);  check(v == 12, "R5 short lock rejected", v, 12);
        check(exp_q.size() == 0, "R5 sweep continued", exp_q.size(), 0);

        // R8 R10: abort from hold, write while busy ignored
        lock_mode = 1; tgt_f = 950; tgt_sr = 0; tgt_pr = 1;
        push_plan(950, 985, 10, 5, 18);
        cmd(8'h01);
        wait_irq("R8 hold before abort");
        wr(4'd0, 1000);
        cmd(8'h03);
        check(irq == 1'b0, "R8 abort clears irq", int'(irq), 0);
        rd(4'd8, v);  check(v == 0, "R8 idle after abort", v, 0);
        rd(4'd0, v);  check(v == 950, "R10 write while busy ignored", v, 950);
        exp_q.delete();
        lock_mode = 0;

        // R9: out-of-band settings rejected
        a0 = attempts;
        wr(4'd0, 900);
        cmd(8'h01);
        repeat (10) @(negedge clk);
        rd(4'd8, v);  check(v == 16, "R9 low start rejected", v, 16);
        wr(4'd0, 950);
        wr(4'd1, 2200);
        cmd(8'h01);
        repeat (10) @(negedge clk);
        rd(4'd8, v);  check(v == 16, "R9 high stop rejected", v, 16);
        check(attempts == a0, "R9 no attempts when rejected", attempts, a0);
        wr(4'd1, 985);
        push_plan(950, 985, 10, 5, 18);
        cmd(8'h01);
        wait_irq("R9 valid sweep runs");
        rd(4'd8, v);  check(v == 12, "R9 error cleared by start", v, 12);

        finish_run();
    end

endmodule